// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Model

This block is a synthesizable model of a pipelined synchronous static RAM that needs no idle cycle when the bus changes direction. The data bus is 18 bits wide and split into two 9-bit lanes. Each lane is eight data bits plus one parity bit, which the model stores like any other bit. Every control, address and byte-enable input is registered on the rising clock edge. Read data appears on the bus two enabled edges after its address. Write data is taken from the bus two enabled edges after its address. Because both directions use the same slot in the pipeline, reads and writes can be issued back to back in any mix.

A new access starts when the load input is low and all three chip selects agree. Holding the load input high continues a burst: the two low address bits step linearly and wrap, and the burst keeps the direction of its load. An active-low clock enable freezes every pipeline stage. An asynchronous sleep input blocks new accesses and keeps the stored contents. The bus is shown as a data output plus an output-enable flag. The flag low means the bus is at high impedance.

Top module: `pipe_sram`

## Requirements
- R1: After reset, `dq_oe` is 0 and no access is in flight. The first enabled edge after reset therefore drives no read data.
- R2: A selected read loaded at enabled edge k sets `dq_oe` to 1 after enabled edge k+2. `dq_o` then carries the stored word, including every write that completed before edge k+2. Reads and writes may alternate on consecutive edges.
- R3: A write loaded at enabled edge k takes `dq_i` at enabled edge k+2. `lane_we_n` is sampled with the address. Bit 0 low writes `dq_i[8:0]` and bit 1 low writes `dq_i[17:9]`. A lane whose bit is 1 keeps its stored value, so a value of 2'b11 writes nothing.
- R4: While `clk_en_n` is 1 and `sleep` is 0, the edge is ignored. `dq_o`, `dq_oe`, the stored array and every pipeline stage hold. Any other input applied on that edge has no effect.
- R5: `rd_wr_n` is sampled only on an edge where `adv_ld_n` is 0. A value of 1 selects read and 0 selects write. While a burst continues, `rd_wr_n` is ignored and the burst keeps its loaded direction.
- R6: An enabled edge with `adv_ld_n` equal to 1, after a selected load, starts the next beat at the address with its two low bits incremented modulo 4. The upper bits stay the same, so the fifth beat returns to the loaded address.
- R7: A load is selected only when `sel_a_n`=0, `sel_b_n`=0 and `sel_c`=1 on that edge. A deselected load makes no access. Continuation edges after it also make no access.
- R8: While `sleep` is 1, every other input is ignored, including `clk_en_n`. No new access starts and the burst state is kept. Accesses already in the pipeline still complete, and stored contents are preserved.
- R9: `dq_oe` is 0 after any enabled edge that does not complete a read: a write, a deselected or empty slot, or a sleep slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline state |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the pipeline |
| adv_ld_n | input | 1 | Low loads a new address, high continues the burst |
| rd_wr_n | input | 1 | Direction at load: 1 read, 0 write |
| sel_a_n | input | 1 | Active-low chip select |
| sel_b_n | input | 1 | Active-low chip select |
| sel_c | input | 1 | Active-high chip select |
| addr | input | ADDR_W | Word address |
| lane_we_n | input | LANES | Active-low per-lane write enables |
| sleep | input | 1 | Asynchronous sleep request |
| dq_i | input | LANES*LANE_W | Write data from the bus |
| dq_o | output | LANES*LANE_W | Read data onto the bus |
| dq_oe | output | 1 | 1 while `dq_o` is valid; 0 means high impedance |

## Verification
Back-to-back mixes of reads and writes to the same few addresses show whether a read sees a write issued just before it. They also show whether the two directions share the right pipeline slot. Partial lane writes with each enable pattern, including all lanes off, separate correct lane masking from whole-word writes. Stalls inside a burst and at the output, plus sleep with garbage on the other inputs, test that held or ignored edges move nothing. Deselected loads under each chip-select pattern, and bursts that toggle the direction input, test that only a selected load starts work and that direction is fixed per burst. A long seeded random mix and a full readback compare everything against a reference array kept in the bench.

// File: rtl/sram_pkg.sv
package sram_pkg;
   typedef enum logic {
      OP_READ  = 1'b0,
      OP_WRITE = 1'b1
   } op_e;
endpackage

// File: rtl/sram_cmd.sv
module sram_cmd
   import sram_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int LANES   = 2,
   parameter int BURST_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              sleep,
   input  logic              load_n,
   input  logic              rd_wr_n,
   input  logic              selected,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [LANES-1:0]  lane_we_n,
   output logic              s1_valid,
   output op_e               s1_op,
   output logic [ADDR_W-1:0] s1_addr,
   output logic [LANES-1:0]  s1_mask
);
   localparam int HI_W = ADDR_W - BURST_W;

   logic              burst_act;
   op_e               burst_op;
   logic [ADDR_W-1:0] burst_addr;
   logic [ADDR_W-1:0] beat_addr;
   op_e               load_op;

   // linear wrap inside the burst window
   assign beat_addr = {burst_addr[ADDR_W-1:BURST_W],
                       burst_addr[BURST_W-1:0] + BURST_W'(1)};
   assign load_op   = rd_wr_n ? OP_READ : OP_WRITE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         burst_act  <= 1'b0;
         burst_op   <= OP_READ;
         burst_addr <= '0;
         s1_valid   <= 1'b0;
         s1_op      <= OP_READ;
         s1_addr    <= '0;
         s1_mask    <= '0;
      end else if (en) begin
         if (sleep) begin
            s1_valid <= 1'b0;
         end else if (!load_n) begin
            burst_act  <= selected;
            burst_op   <= load_op;
            burst_addr <= addr_i;
            s1_valid   <= selected;
            s1_op      <= load_op;
            s1_addr    <= addr_i;
            s1_mask    <= ~lane_we_n;
         end else if (burst_act) begin
            burst_addr <= beat_addr;
            s1_valid   <= 1'b1;
            s1_op      <= burst_op;
            s1_addr    <= beat_addr;
            s1_mask    <= ~lane_we_n;
         end else begin
            s1_valid <= 1'b0;
         end
      end
   end

   AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !sleep && load_n && burst_act) |=>
         (s1_addr[BURST_W-1:0] == $past(s1_addr[BURST_W-1:0]) + BURST_W'(1)) &&
         (s1_addr[ADDR_W-1:BURST_W] == $past(s1_addr[ADDR_W-1:BURST_W])))
      else $error("burst beat address wrong"); // R6

   AST_DIR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !sleep && load_n && burst_act) |=> (s1_valid && s1_op == $past(s1_op)))
      else $error("burst changed direction"); // R5

   AST_DESEL_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !sleep && !load_n && !selected) |=> !s1_valid)
      else $error("deselected load started an access"); // R7

   AST_SLEEP_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> !s1_valid)
      else $error("access started during sleep"); // R8

   logic unused_hi;
   assign unused_hi = (HI_W < 0);
endmodule

// File: rtl/sram_pipe.sv
module sram_pipe
   import sram_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LANES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              s1_valid,
   input  op_e               s1_op,
   input  logic [ADDR_W-1:0] s1_addr,
   input  logic [LANES-1:0]  s1_mask,
   output logic              mem_we,
   output logic              mem_re,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [LANES-1:0]  mem_mask,
   output logic              dq_oe
);
   logic              s2_valid;
   op_e               s2_op;
   logic [ADDR_W-1:0] s2_addr;
   logic [LANES-1:0]  s2_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_valid <= 1'b0;
         s2_op    <= OP_READ;
         s2_addr  <= '0;
         s2_mask  <= '0;
         dq_oe    <= 1'b0;
      end else if (en) begin
         s2_valid <= s1_valid;
         s2_op    <= s1_op;
         s2_addr  <= s1_addr;
         s2_mask  <= s1_mask;
         dq_oe    <= s2_valid && (s2_op == OP_READ);
      end
   end

   // both directions complete in the same slot: no turnaround gap
   assign mem_we   = en && s2_valid && (s2_op == OP_WRITE);
   assign mem_re   = en && s2_valid && (s2_op == OP_READ);
   assign mem_addr = s2_addr;
   assign mem_mask = s2_mask;

   AST_OE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !dq_oe)
      else $error("bus driven right after reset"); // R1

   AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !(s2_valid && s2_op == OP_READ)) |=> !dq_oe)
      else $error("bus driven without a read"); // R9
endmodule

// File: rtl/sram_array.sv
module sram_array #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 2,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic                    re,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES-1:0]        mask,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] store [DEPTH];
      logic [LANE_W-1:0] lane_q;

      always_ff @(posedge clk) begin
         if (we && mask[g]) store[addr] <= wdata[g*LANE_W +: LANE_W];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  lane_q <= '0;
         else if (re) lane_q <= store[addr];
      end

      assign rdata[g*LANE_W +: LANE_W] = lane_q;
   end

   always_comb begin
      AST_PORT_EXCLUSIVE: assert (!(we && re)) else $error("read and write in one slot"); // R2
   end
endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
   import sram_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int LANES   = 2,
   parameter int LANE_W  = 9,
   parameter int BURST_W = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clk_en_n,
   input  logic                    adv_ld_n,
   input  logic                    rd_wr_n,
   input  logic                    sel_a_n,
   input  logic                    sel_b_n,
   input  logic                    sel_c,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES-1:0]        lane_we_n,
   input  logic                    sleep,
   input  logic [LANES*LANE_W-1:0] dq_i,
   output logic [LANES*LANE_W-1:0] dq_o,
   output logic                    dq_oe
);
   initial begin
      assert (ADDR_W > BURST_W) else $error("ADDR_W must exceed BURST_W");
      assert (BURST_W >= 1)     else $error("BURST_W must be at least 1");
      assert (LANES >= 1)       else $error("LANES must be at least 1");
      assert (LANE_W >= 1)      else $error("LANE_W must be at least 1");
   end

   logic              en;
   logic              selected;
   logic              s1_valid;
   op_e               s1_op;
   logic [ADDR_W-1:0] s1_addr;
   logic [LANES-1:0]  s1_mask;
   logic              mem_we;
   logic              mem_re;
   logic [ADDR_W-1:0] mem_addr;
   logic [LANES-1:0]  mem_mask;

   // sleep overrides the clock enable so in-flight work drains
   assign en       = sleep || !clk_en_n;
   assign selected = !sel_a_n && !sel_b_n && sel_c;

   sram_cmd #(.ADDR_W(ADDR_W), .LANES(LANES), .BURST_W(BURST_W)) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .sleep     (sleep),
      .load_n    (adv_ld_n),
      .rd_wr_n   (rd_wr_n),
      .selected  (selected),
      .addr_i    (addr),
      .lane_we_n (lane_we_n),
      .s1_valid  (s1_valid),
      .s1_op     (s1_op),
      .s1_addr   (s1_addr),
      .s1_mask   (s1_mask)
   );

   sram_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pipe (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .s1_valid (s1_valid),
      .s1_op    (s1_op),
      .s1_addr  (s1_addr),
      .s1_mask  (s1_mask),
      .mem_we   (mem_we),
      .mem_re   (mem_re),
      .mem_addr (mem_addr),
      .mem_mask (mem_mask),
      .dq_oe    (dq_oe)
   );

   sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (mem_we),
      .re    (mem_re),
      .addr  (mem_addr),
      .mask  (mem_mask),
      .wdata (dq_i),
      .rdata (dq_o)
   );

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && clk_en_n) |=> ($stable(dq_o) && $stable(dq_oe)))
      else $error("outputs moved on a stalled edge"); // R4
endmodule

// File: tb/pipe_sram_test.sv
module pipe_sram_test;
   localparam int CLK_PERIOD = 10;
   localparam int AW    = 8;
   localparam int LANES = 2;
   localparam int LW    = 9;
   localparam int DW    = LANES * LW;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b1;
   logic          clk_en_n = 1'b0, adv_ld_n = 1'b0, rd_wr_n = 1'b1;
   logic          sel_a_n = 1'b1, sel_b_n = 1'b1, sel_c = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [1:0]    lane_we_n = 2'b11;
   logic          sleep = 1'b0;
   logic [DW-1:0] dq_i = '0;
   logic [DW-1:0] dq_o;
   logic          dq_oe;

   pipe_sram #(.ADDR_W(AW), .LANES(LANES), .LANE_W(LW), .BURST_W(2)) uut (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .adv_ld_n(adv_ld_n),
      .rd_wr_n(rd_wr_n), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_c(sel_c),
      .addr(addr), .lane_we_n(lane_we_n), .sleep(sleep), .dq_i(dq_i),
      .dq_o(dq_o), .dq_oe(dq_oe)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // reference model state
   logic [DW-1:0] ref_mem [DEPTH];
   bit            p_v  [2];
   bit            p_wr [2];
   logic [AW-1:0] p_a  [2];
   logic [1:0]    p_m  [2];
   bit            b_act = 1'b0;
   bit            b_wr  = 1'b0;
   logic [AW-1:0] b_a   = '0;
   bit            exp_oe = 1'b0;
   logic [DW-1:0] exp_dq = '0;

   int    checks = 0;
   int    fails  = 0;
   bit    done   = 1'b0;
   string tag    = "R1";

   function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                           input logic [DW-1:0] new_w,
                                           input logic [1:0] en_mask);
      logic [DW-1:0] r = old_w;
      for (int l = 0; l < LANES; l++)
         if (en_mask[l]) r[l*LW +: LW] = new_w[l*LW +: LW];
      return r;
   endfunction

   function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
      return {a[AW-1:2], a[1:0] + 2'd1};
   endfunction

   task automatic model_edge();
      bit en = sleep || !clk_en_n;
      if (!en) return;
      // oldest slot completes
      exp_oe = p_v[1] && !p_wr[1];
      if (p_v[1] && p_wr[1]) ref_mem[p_a[1]] = merge(ref_mem[p_a[1]], dq_i, p_m[1]);
      if (exp_oe) exp_dq = ref_mem[p_a[1]];
      p_v[1] = p_v[0]; p_wr[1] = p_wr[0]; p_a[1] = p_a[0]; p_m[1] = p_m[0];
      if (sleep) begin
         p_v[0] = 1'b0;
      end else if (!adv_ld_n) begin
         b_act = !sel_a_n && !sel_b_n && sel_c;
         b_wr  = !rd_wr_n;
         b_a   = addr;
         p_v[0] = b_act; p_wr[0] = b_wr; p_a[0] = addr; p_m[0] = ~lane_we_n;
      end else if (b_act) begin
         b_a = step_addr(b_a);
         p_v[0] = 1'b1; p_wr[0] = b_wr; p_a[0] = b_a; p_m[0] = ~lane_we_n;
      end else begin
         p_v[0] = 1'b0;
      end
   endtask

   task automatic check_out();
      string req = exp_oe ? tag : "R9";
      checks++;
      if (dq_oe !== exp_oe) begin
         fails++;
         $display("FAIL %s dq_oe actual=%0b expected=%0b", req, dq_oe, exp_oe);
      end
      if (exp_oe) begin
         checks++;
         if (dq_o !== exp_dq) begin
            fails++;
            $display("FAIL %s dq_o actual=%h expected=%h", tag, dq_o, exp_dq);
         end
      end
   endtask

   // cs: {sel_a_n, sel_b_n, sel_c}; 3'b001 selects
   task automatic cyc(input bit cen, input bit ld, input bit rw, input logic [2:0] cs,
                      input logic [AW-1:0] a, input logic [1:0] bwn, input bit slp);
      clk_en_n = cen; adv_ld_n = ld; rd_wr_n = rw;
      {sel_a_n, sel_b_n, sel_c} = cs;
      addr = a; lane_we_n = bwn; sleep = slp; dq_i = DW'($urandom);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check_out();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b1, 3'b110, '0, 2'b11, 1'b0);
   endtask

   task automatic burst(input bit rw, input logic [AW-1:0] a, input logic [1:0] bwn);
      cyc(1'b0, 1'b0, rw, 3'b001, a, bwn, 1'b0);
      for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, rw, 3'b001, '0, bwn, 1'b0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      p_v[0] = 0; p_v[1] = 0; p_wr[0] = 0; p_wr[1] = 0;
      p_a[0] = '0; p_a[1] = '0; p_m[0] = '0; p_m[1] = '0;
      #1 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      tag = "R1";
      checks++;
      if (dq_oe !== 1'b0) begin
         fails++; $display("FAIL R1 dq_oe in reset actual=%0b expected=0", dq_oe);
      end
      rst_n = 1'b1;
      // R1: first cycles after reset drive nothing
      idle(2);

      // R6: fill the array with wrapping write bursts
      tag = "R6";
      for (int k = 0; k < DEPTH/4; k++) burst(1'b0, AW'(k*4), 2'b00);
      // R6: wrap check, five beats of a read burst started mid window
      cyc(1'b0, 1'b0, 1'b1, 3'b001, 8'd42, 2'b11, 1'b0);
      for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 1'b1, 3'b001, '0, 2'b11, 1'b0);
      idle(2);

      // R2: reads and writes alternate with no idle cycle
      tag = "R2";
      for (int i = 0; i < 24; i++)
         cyc(1'b0, 1'b0, i[0], 3'b001, AW'(i % 3), 2'b00, 1'b0);
      idle(2);

      // R3: each lane enable pattern, then read back
      tag = "R3";
      cyc(1'b0, 1'b0, 1'b0, 3'b001, 8'd5, 2'b10, 1'b0);
      cyc(1'b0, 1'b0, 1'b0, 3'b001, 8'd6, 2'b01, 1'b0);
      cyc(1'b0, 1'b0, 1'b0, 3'b001, 8'd7, 2'b11, 1'b0);
      cyc(1'b0, 1'b0, 1'b1, 3'b001, 8'd5, 2'b11, 1'b0);
      cyc(1'b0, 1'b0, 1'b1, 3'b001, 8'd6, 2'b11, 1'b0);
      cyc(1'b0, 1'b0, 1'b1, 3'b001, 8'd7, 2'b11, 1'b0);
      idle(2);

      // R4: stalls mid burst with garbage on other inputs
      tag = "R4";
      cyc(1'b0, 1'b0, 1'b1, 3'b001, 8'd8, 2'b11, 1'b0);
      cyc(1'b0, 1'b1, 1'b1, 3'b001, '0, 2'b11, 1'b0);
      for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b0, 3'b001, 8'd99, 2'b00, 1'b0);
      cyc(1'b0, 1'b1, 1'b1, 3'b001, '0, 2'b11, 1'b0);
      cyc(1'b1, 1'b0, 1'b0, 3'b001, 8'd9, 2'b00, 1'b0);
      cyc(1'b0, 1'b1, 1'b1, 3'b001, '0, 2'b11, 1'b0);
      // R4: stalled write slot must not take stall-time data
      cyc(1'b0, 1'b0, 1'b0, 3'b001, 8'd10, 2'b00, 1'b0);
      cyc(1'b0, 1'b0, 1'b1, 3'b110, '0, 2'b11, 1'b0);
      cyc(1'b1, 1'b0, 1'b1, 3'b001, '0, 2'b11, 1'b0);
      cyc(1'b0, 1'b0, 1'b1, 3'b001, 8'd10, 2'b11, 1'b0);
      idle(2);

      // R5: direction toggles during bursts are ignored
      tag = "R5";
      cyc(1'b0, 1'b0, 1'b0, 3'b001, 8'd16, 2'b00, 1'b0);
      for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 1'b1, 3'b001, '0, 2'b00, 1'b0);
      cyc(1'b0, 1'b0, 1'b1, 3'b001, 8'd16, 2'b00, 1'b0);
      for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 1'b0, 3'b001, '0, 2'b00, 1'b0);
      idle(2);

      // R7: each deselect pattern, then continuations, then read back
      tag = "R7";
      cyc(1'b0, 1'b0, 1'b0, 3'b101, 8'd20, 2'b00, 1'b0);
      cyc(1'b0, 1'b1, 1'b0, 3'b001, '0, 2'b00, 1'b0);
      cyc(1'b0, 1'b0, 1'b0, 3'b011, 8'd20, 2'b00, 1'b0);
      cyc(1'b0, 1'b1, 1'b0, 3'b001, '0, 2'b00, 1'b0);
      cyc(1'b0, 1'b0, 1'b0, 3'b000, 8'd20, 2'b00, 1'b0);
      cyc(1'b0, 1'b1, 1'b0, 3'b001, '0, 2'b00, 1'b0);
      idle(2);
      burst(1'b1, 8'd20, 2'b11);
      idle(2);

      // R8: sleep right after a write and a read, other inputs hostile
      tag = "R8";
      cyc(1'b0, 1'b0, 1'b0, 3'b001, 8'd24, 2'b00, 1'b0);
      cyc(1'b0, 1'b0, 1'b1, 3'b001, 8'd25, 2'b11, 1'b0);
      for (int i = 0; i < 4; i++) cyc(1'b1, i[0], 1'b0, 3'b001, 8'd26, 2'b00, 1'b1);
      cyc(1'b0, 1'b1, 1'b0, 3'b001, '0, 2'b00, 1'b0);
      idle(2);
      burst(1'b1, 8'd24, 2'b11);
      idle(2);

      // R2: seeded random mix of everything
      tag = "R2";
      for (int i = 0; i < 1200; i++) begin
         logic [2:0] cs = ($urandom_range(0, 9) < 8) ? 3'b001 : 3'($urandom);
         cyc(($urandom_range(0, 9) == 0), ($urandom_range(0, 9) < 4), 1'($urandom), cs,
             AW'($urandom_range(0, 15)), 2'($urandom), ($urandom_range(0, 39) == 0));
      end
      idle(3);

      // R3: full readback against the reference array
      tag = "R3";
      for (int k = 0; k < DEPTH/4; k++) burst(1'b1, AW'(k*4), 2'b11);
      idle(2);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL R2 watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule